// File: doc/BRIEF.md
# Interpolated Flying-Adder Edge Sequencer

This block is a cycle-level model of a two-path interpolated flying adder. Time is measured in units of Δ, the spacing between neighbouring taps of a 32-tap reference phase ring. Each pulse on `strobe` stands for one synthesized output edge. On that pulse the main accumulator adds the frequency word. Path A's edge then moves to the next phase tap, and path B takes the tap path A held one edge earlier, shifted by a phase-control offset.

Both edges are kept as unbounded counts. The interpolated output edge is reported as their sum, which is the midpoint of the two edges expressed in half-Δ units. The spacing from the previous output edge is also reported. When a fractional carry lengthens one cycle, the interpolated output spreads that extra Δ over two consecutive edges, so the step between neighbouring intervals is only half a Δ.

The block produces the tap select codes for both paths and the edge timing. A surrounding testbench or system model can use these to study jitter patterns. The oscillator, the analog multiplexer and the interpolating cell are not part of it.

Top module: `ifa_edge_seq`

## Requirements
- R1: A synchronous active-high `rst` clears both accumulators, both edge times, the output time, the interval, `out_valid` and both divide-by-2 levels to zero.
- R2: `fcw` is split with bits [28:24] as the integer part and bits [23:0] as the fraction of one Δ. On each strobe, path A's edge time grows by the integer part plus the carry out of the 24-bit fractional sum. `sel_a` always equals the low 5 bits of path A's edge time.
- R3: On each strobe, path B's edge time becomes path A's edge time from before that strobe plus `phase_ctl` (in Δ). `sel_b` always equals the low 5 bits of path B's edge time.
- R4: `out_time` equals `edge_a_time + edge_b_time`, the midpoint of the two edges in half-Δ units. `out_interval` is the new `out_time` minus the previous one, modulo 2^(TIME_W+1).
- R5: `out_valid` is high for exactly the one clock after each strobe. Every output changes only on a strobe clock.
- R6: `path_a_lvl` and `path_b_lvl` each toggle once per strobe, which gives a divide-by-2 waveform with 50% duty in edge count.
- R7: Changes on `fcw` and `phase_ctl` while `strobe` is low leave every output unchanged. A new value takes effect only at the next strobe.
- R8: With a constant word and after the start-up edges, the interval takes at most two values, and they differ by one half-Δ. Over a whole fractional period, the intervals sum to 2·fcw·period half-Δ. A word of 3.25 gives the repeating pattern 6, 6, 7, 7.
- R9: The select codes wrap modulo 32 while the edge times keep counting past 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | One pulse per synthesized output edge |
| fcw | input | 29 | Frequency word: 5 integer bits over 24 fraction bits |
| phase_ctl | input | 5 | Path B offset in Δ |
| sel_a | output | 5 | Path A tap select |
| sel_b | output | 5 | Path B tap select |
| edge_a_time | output | 32 | Path A edge time in Δ |
| edge_b_time | output | 32 | Path B edge time in Δ |
| out_time | output | 33 | Interpolated edge time in half-Δ |
| out_interval | output | 33 | Latest output interval in half-Δ |
| out_valid | output | 1 | High for the clock after each strobe |
| path_a_lvl | output | 1 | Path A divide-by-2 level |
| path_b_lvl | output | 1 | Path B divide-by-2 level |

## Verification
The word 3.25 separates the interpolated output (6, 6, 7, 7) from a single path (3, 3, 3, 4 in Δ). A word of 7.5 shows the carry being cancelled completely, giving a flat 15. A whole word of 5.0 shows that no carry path leaks in when the fraction is zero. A word of 9 + 1/16 is run through its full fractional period and checked for two adjacent interval values and the exact mean. A phase offset step exposes path B's lag and offset, and a word near 31.5 drives both selects around the ring many times.

// File: rtl/ifa_pkg.sv
package ifa_pkg;
   localparam int unsigned IFA_INT_W_DEF  = 5;
   localparam int unsigned IFA_FRAC_W_DEF = 24;
   localparam int unsigned IFA_TIME_W_DEF = 32;

   function automatic int unsigned ifa_ring_taps(input int unsigned int_w);
      return 32'd1 << int_w;
   endfunction
endpackage

// File: rtl/ifa_main_acc.sv
module ifa_main_acc #(
   parameter int unsigned INT_W  = 5,
   parameter int unsigned FRAC_W = 24,
   parameter int unsigned TIME_W = 32,
   localparam int unsigned ACC_W = INT_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic [ACC_W-1:0]  fcw,
   output logic [INT_W-1:0]  sel_q,
   output logic [INT_W-1:0]  reg_a_q,
   output logic [TIME_W-1:0] edge_q,
   output logic [TIME_W-1:0] edge_d
);
   logic [ACC_W-1:0]  acc_q;
   logic [ACC_W-1:0]  acc_d;
   logic [FRAC_W:0]   frac_sum;
   logic [TIME_W-1:0] step;

   always_comb begin
      frac_sum = {1'b0, acc_q[FRAC_W-1:0]} + {1'b0, fcw[FRAC_W-1:0]};
      step     = TIME_W'(fcw[ACC_W-1:FRAC_W]) + TIME_W'(frac_sum[FRAC_W]);
      acc_d    = acc_q + fcw;
      edge_d   = strobe ? edge_q + step : edge_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         edge_q  <= '0;
         reg_a_q <= '0;
      end else if (strobe) begin
         acc_q   <= acc_d;
         edge_q  <= edge_d;
         reg_a_q <= acc_d[ACC_W-1:FRAC_W];
      end
   end

   assign sel_q = acc_q[ACC_W-1:FRAC_W];

   // R2: the wrapped accumulator integer and the unbounded edge count agree on the tap
   a_r2_sel_tracks_edge: assert property (@(posedge clk) disable iff (rst)
      sel_q == edge_q[INT_W-1:0]);
   // R2: each edge advances by the integer part, plus at most one carry
   a_r2_step_bounds: assert property (@(posedge clk) disable iff (rst)
      strobe |=> (edge_q - $past(edge_q)) - TIME_W'($past(fcw[ACC_W-1:FRAC_W])) <= TIME_W'(1));
   // R7: nothing moves without a strobe
   a_r7_acc_hold: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(acc_q) && $stable(edge_q));
endmodule

// File: rtl/ifa_path_b.sv
module ifa_path_b #(
   parameter int unsigned INT_W  = 5,
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic [INT_W-1:0]  phase_ctl,
   input  logic [INT_W-1:0]  reg_a_q,
   input  logic [TIME_W-1:0] edge_a_q,
   output logic [INT_W-1:0]  reg_b_q,
   output logic [TIME_W-1:0] edge_q,
   output logic [TIME_W-1:0] edge_d
);
   assign edge_d = strobe ? edge_a_q + TIME_W'(phase_ctl) : edge_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_b_q <= '0;
         edge_q  <= '0;
      end else if (strobe) begin
         reg_b_q <= reg_a_q + phase_ctl;
         edge_q  <= edge_d;
      end
   end

   // R3: 5-bit select register and unbounded path B time stay on the same tap
   a_r3_sel_b_ring: assert property (@(posedge clk) disable iff (rst)
      reg_b_q == edge_q[INT_W-1:0]);
   // R7: path B holds between strobes
   a_r7_b_hold: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(edge_q) && $stable(reg_b_q));
endmodule

// File: rtl/ifa_interp.sv
module ifa_interp #(
   parameter int unsigned TIME_W = 32,
   localparam int unsigned OUT_W = TIME_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic [TIME_W-1:0] edge_a_d,
   input  logic [TIME_W-1:0] edge_b_d,
   output logic [OUT_W-1:0]  out_q,
   output logic [OUT_W-1:0]  iv_q,
   output logic              valid_q
);
   logic [OUT_W-1:0] mid_d;

   assign mid_d = {1'b0, edge_a_d} + {1'b0, edge_b_d};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_q   <= '0;
         iv_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= strobe;
         if (strobe) begin
            out_q <= mid_d;
            iv_q  <= mid_d - out_q;
         end
      end
   end

   // R5: one valid pulse per strobe, one clock later
   a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
      strobe |=> valid_q);
   a_r5_valid_quiet: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> !valid_q && $stable(out_q) && $stable(iv_q));
endmodule

// File: rtl/ifa_edge_seq.sv
module ifa_edge_seq
   import ifa_pkg::*;
#(
   parameter int unsigned INT_W  = IFA_INT_W_DEF,
   parameter int unsigned FRAC_W = IFA_FRAC_W_DEF,
   parameter int unsigned TIME_W = IFA_TIME_W_DEF,
   localparam int unsigned ACC_W = INT_W + FRAC_W,
   localparam int unsigned OUT_W = TIME_W + 1,
   localparam int unsigned TAPS  = ifa_ring_taps(INT_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              strobe,
   input  logic [ACC_W-1:0]  fcw,
   input  logic [INT_W-1:0]  phase_ctl,
   output logic [INT_W-1:0]  sel_a,
   output logic [INT_W-1:0]  sel_b,
   output logic [TIME_W-1:0] edge_a_time,
   output logic [TIME_W-1:0] edge_b_time,
   output logic [OUT_W-1:0]  out_time,
   output logic [OUT_W-1:0]  out_interval,
   output logic              out_valid,
   output logic              path_a_lvl,
   output logic              path_b_lvl
);
   if (INT_W < 1 || INT_W > 8) begin : g_bad_int
      $error("INT_W must lie in 1..8");
   end
   if (FRAC_W < 1) begin : g_bad_frac
      $error("FRAC_W must be at least 1");
   end
   if (TIME_W <= INT_W + 1) begin : g_bad_time
      $error("TIME_W must exceed INT_W + 1");
   end
   if (TAPS < 2) begin : g_bad_taps
      $error("phase ring needs at least two taps");
   end

   logic [INT_W-1:0]  reg_a_q;
   logic [TIME_W-1:0] edge_a_d;
   logic [TIME_W-1:0] edge_b_d;
   logic [TIME_W-1:0] lo_edge;
   logic [TIME_W-1:0] hi_edge;

   ifa_main_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .TIME_W(TIME_W)) u_main (
      .clk(clk), .rst(rst), .strobe(strobe), .fcw(fcw),
      .sel_q(sel_a), .reg_a_q(reg_a_q), .edge_q(edge_a_time), .edge_d(edge_a_d));

   ifa_path_b #(.INT_W(INT_W), .TIME_W(TIME_W)) u_path_b (
      .clk(clk), .rst(rst), .strobe(strobe), .phase_ctl(phase_ctl),
      .reg_a_q(reg_a_q), .edge_a_q(edge_a_time),
      .reg_b_q(sel_b), .edge_q(edge_b_time), .edge_d(edge_b_d));

   ifa_interp #(.TIME_W(TIME_W)) u_interp (
      .clk(clk), .rst(rst), .strobe(strobe),
      .edge_a_d(edge_a_d), .edge_b_d(edge_b_d),
      .out_q(out_time), .iv_q(out_interval), .valid_q(out_valid));

   for (genvar p = 0; p < 2; p++) begin : g_div
      logic lvl;
      always_ff @(posedge clk) begin
         if (rst)         lvl <= 1'b0;
         else if (strobe) lvl <= ~lvl;
      end
      // R6: every selected edge flips this path's divider
      a_r6_toggle: assert property (@(posedge clk) disable iff (rst)
         strobe |=> lvl != $past(lvl));
   end

   assign path_a_lvl = g_div[0].lvl;
   assign path_b_lvl = g_div[1].lvl;

   always_comb begin
      lo_edge = (edge_a_time < edge_b_time) ? edge_a_time : edge_b_time;
      hi_edge = (edge_a_time < edge_b_time) ? edge_b_time : edge_a_time;
   end

   // R4: the interpolated edge lies between the two path edges
   a_r4_midpoint_bounds: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_time >= {lo_edge, 1'b0}) && (out_time <= {hi_edge, 1'b0}));
   // R1: the first clock out of reset shows a cleared block
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (out_time == '0) && !out_valid && (edge_a_time == '0) && (edge_b_time == '0));
endmodule

// File: tb/ifa_edge_seq_tb.sv
`timescale 1ns/1ps
module ifa_edge_seq_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        strobe = 1'b0;
   logic [28:0] fcw = '0;
   logic [4:0]  phase_ctl = '0;
   logic [4:0]  sel_a, sel_b;
   logic [31:0] edge_a_time, edge_b_time;
   logic [32:0] out_time, out_interval;
   logic        out_valid, path_a_lvl, path_b_lvl;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   logic [23:0] m_frac;
   logic [31:0] m_ea, m_eb;
   logic [32:0] m_out, m_iv;
   int          m_count;

   always #2 clk = ~clk;

   ifa_edge_seq u_dut (
      .clk(clk), .rst(rst), .strobe(strobe), .fcw(fcw), .phase_ctl(phase_ctl),
      .sel_a(sel_a), .sel_b(sel_b), .edge_a_time(edge_a_time), .edge_b_time(edge_b_time),
      .out_time(out_time), .out_interval(out_interval), .out_valid(out_valid),
      .path_a_lvl(path_a_lvl), .path_b_lvl(path_b_lvl));

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   task automatic model_clear();
      m_frac = '0; m_ea = '0; m_eb = '0; m_out = '0; m_iv = '0; m_count = 0;
   endtask

   task automatic model_step(input logic [28:0] w, input logic [4:0] ph);
      logic [24:0] s;
      logic [31:0] old_a;
      logic [32:0] nout;
      s      = {1'b0, m_frac} + {1'b0, w[23:0]};
      old_a  = m_ea;
      m_ea   = m_ea + 32'(w[28:24]) + 32'(s[24]);
      m_frac = s[23:0];
      m_eb   = old_a + 32'(ph);
      nout   = {1'b0, m_ea} + {1'b0, m_eb};
      m_iv   = nout - m_out;
      m_out  = nout;
      m_count++;
   endtask

   task automatic compare_all(input string tag);
      check({tag, " R2 sel_a"},   64'(sel_a),        64'(m_ea[4:0]));
      check({tag, " R2 edge_a"},  64'(edge_a_time),  64'(m_ea));
      check({tag, " R3 sel_b"},   64'(sel_b),        64'(m_eb[4:0]));
      check({tag, " R3 edge_b"},  64'(edge_b_time),  64'(m_eb));
      check({tag, " R4 out"},     64'(out_time),     64'(m_out));
      check({tag, " R4 iv"},      64'(out_interval), 64'(m_iv));
      check({tag, " R6 lvl_a"},   64'(path_a_lvl),   64'(m_count % 2));
      check({tag, " R6 lvl_b"},   64'(path_b_lvl),   64'(m_count % 2));
   endtask

   // drives one strobe; caller stands at a falling edge
   task automatic pulse(input logic [28:0] w, input logic [4:0] ph, input string tag);
      fcw = w; phase_ctl = ph; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      model_step(w, ph);
      check({tag, " R5 valid"}, 64'(out_valid), 64'd1);
      compare_all(tag);
   endtask

   task automatic t_reset();
      rst = 1'b1; strobe = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      model_clear();
      check("R1 valid", 64'(out_valid), 64'd0);
      compare_all("R1 reset");
   endtask

   task automatic t_example();
      logic [32:0] exp_pat [4] = '{33'd6, 33'd6, 33'd7, 33'd7};
      t_reset();
      for (int i = 0; i < 9; i++) begin
         pulse({5'd3, 24'h400000}, 5'd0, "R8 w3.25");
         if (i >= 1)
            check("R8 pattern 6,6,7,7", 64'(out_interval), 64'(exp_pat[(i - 1) % 4]));
      end
   endtask

   task automatic t_no_strobe();
      logic [32:0] keep_out;
      logic [31:0] keep_a;
      keep_out = out_time; keep_a = edge_a_time;
      fcw = {5'd17, 24'hABCDEF}; phase_ctl = 5'd9;
      repeat (3) @(negedge clk);
      check("R7 out held",   64'(out_time),    64'(keep_out));
      check("R7 edge held",  64'(edge_a_time), 64'(keep_a));
      check("R5 valid low",  64'(out_valid),   64'd0);
      compare_all("R7 idle");
   endtask

   task automatic t_half();
      t_reset();
      for (int i = 0; i < 6; i++) begin
         pulse({5'd7, 24'h800000}, 5'd0, "R8 w7.5");
         if (i >= 1) check("R8 flat 15", 64'(out_interval), 64'd15);
      end
   endtask

   task automatic t_whole();
      t_reset();
      for (int i = 0; i < 5; i++) begin
         pulse({5'd5, 24'h0}, 5'd0, "R2 w5");
         if (i >= 1) check("R2 flat 10", 64'(out_interval), 64'd10);
      end
   endtask

   task automatic t_phase();
      t_reset();
      pulse({5'd4, 24'h0}, 5'd0, "R3 ph0");
      pulse({5'd4, 24'h0}, 5'd0, "R3 ph0");
      pulse({5'd4, 24'h0}, 5'd4, "R3 ph4");
      check("R3 offset step", 64'(out_interval), 64'd12);
      pulse({5'd4, 24'h0}, 5'd4, "R3 ph4");
      check("R3 offset steady", 64'(out_interval), 64'd8);
      check("R3 b ahead", 64'(edge_b_time), 64'(edge_a_time));
   endtask

   task automatic t_wrap();
      t_reset();
      for (int i = 0; i < 40; i++) pulse({5'd31, 24'h800000}, 5'd3, "R9 wrap");
      check("R9 time past ring", 64'(edge_a_time > 32'd1000), 64'd1);
      check("R9 sel_a mod 32", 64'(sel_a), 64'(edge_a_time % 32));
   endtask

   task automatic t_stats();
      int lo = 1 << 30;
      int hi = 0;
      int sum = 0;
      t_reset();
      for (int i = 0; i < 4; i++) pulse({5'd9, 24'h100000}, 5'd0, "R8 warm");
      for (int i = 0; i < 16; i++) begin
         pulse({5'd9, 24'h100000}, 5'd0, "R8 period");
         sum += int'(out_interval);
         if (int'(out_interval) < lo) lo = int'(out_interval);
         if (int'(out_interval) > hi) hi = int'(out_interval);
      end
      check("R8 two adjacent values", 64'(hi - lo), 64'd1);
      check("R8 mean equals word", 64'(sum), 64'd290);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_example();
      t_no_strobe();
      t_half();
      t_whole();
      t_phase();
      t_wrap();
      t_stats();
      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         report();
         $finish;
      end
   end
endmodule